// File: doc/BRIEF.md
# Multicycle Register-Memory Add Core

This block is a compact multicycle processor core that runs a single instruction: add a 16-bit half-word from memory to a register. Every instruction is 32 bits wide and is read as two half-words over a 16-bit read-only memory port. The core decodes the opcode and forms the operand address as a displacement plus a base register. It then reads the operand, adds it to a destination register with 16-bit two's-complement arithmetic, and writes the sum back. Finally it advances the program counter and starts on the following instruction.

The sequencer spends a fixed number of states on each step. There is one state for each of the following: decode, second fetch, address calculation, operand fetch, add, write-back, PC increment and PC save. Each fetch state waits for as long as the memory keeps its ready signal low. An unknown opcode halts the core until reset and raises a sticky status bit. A signed overflow on the add raises a second status bit, and the wrapped sum is still written.

Top module: `addCore`

## Requirements
- R1: A synchronous active-high `rst` clears the program counter, all 16 registers and both status bits. The first read after reset is of address 0.
- R2: The instruction half-word read at address PC holds the opcode in bits 15:8, the destination register index in bits 7:4 and the base register index in bits 3:0. The half-word read at PC+1 is the 16-bit displacement. The only accepted opcode is 0x5A.
- R3: The operand read address equals the displacement plus the base register, modulo 2^16.
- R4: The destination register receives its old value plus the operand, wrapped to 16 bits. The next instruction sees the new value.
- R5: `status[0]` shows the signed overflow of the most recent add, meaning both inputs have the same sign and the sum has the other sign. The flag is updated at the end of the add state. The wrapped sum is still written.
- R6: While `memRead` is high and `memReady` is low, `memRead` stays high and `memAddr` holds its value. A read completes at a rising edge where both are high, and the data is sampled at that edge.
- R7: Every completed read is followed by a cycle with `memRead` low. Consecutive completed first-half-word reads are 9 cycles apart plus the wait cycles of the three reads involved.
- R8: The first half-word of the next instruction is read at PC+2.
- R9: An opcode other than 0x5A sets `status[1]`. After that, `memRead` stays low and `status[1]` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| memAddr | output | 16 | Half-word read address |
| memRead | output | 1 | Read request strobe |
| memData | input | 16 | Read data, sampled when the read completes |
| memReady | input | 1 | Read completion handshake |
| status | output | 2 | Bit 0: signed overflow of last add; bit 1: sticky illegal-opcode halt |

## Verification
The bench acts as the memory and inserts 0 to 2 random wait cycles on each read. It sets `memReady` at a falling edge, so the read completes at the next rising edge. It then checks, at the falling edge after that, that the strobe has dropped. The next first-half-word read must complete exactly 9 cycles after the previous one, plus that instruction's wait cycles. The bench measures this with its own cycle counter. The overflow flag is due one cycle after the operand read completes (the add state), so it is sampled one falling edge later. Register results cannot be seen directly; each one is checked through the operand address of a later instruction that uses that register as its base.

// File: rtl/addCorePkg.sv
package addCorePkg;

  localparam int STAT_W   = 2;
  localparam int STAT_OVF = 0;
  localparam int STAT_ILL = 1;

  typedef enum logic [3:0] {
    ST_FETCH_HI,
    ST_DECODE,
    ST_FETCH_LO,
    ST_CALC,
    ST_FETCH_OPND,
    ST_EXEC,
    ST_WRITE,
    ST_PC_INC,
    ST_PC_SAVE,
    ST_HALT
  } seqState_t;

  typedef enum logic [1:0] {
    ADR_PC,
    ADR_PC_NEXT,
    ADR_OPND
  } addrSel_t;

  typedef struct packed {
    logic     loadHi;
    logic     loadLo;
    logic     calcAddr;
    logic     loadOpnd;
    logic     doAdd;
    logic     writeDst;
    logic     incPc;
    logic     savePc;
    addrSel_t addrSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/addCoreRegFile.sv
module addCoreRegFile #(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 16,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [IDX_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData
);

  logic [DATA_W-1:0] regs [REG_CNT];

  always_ff @(posedge clk) begin
    for (int i = 0; i < REG_CNT; i++) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (wrEn && wrIdx == IDX_W'(i)) begin
        regs[i] <= wrData;
      end
    end
  end

  assign rdDataA = regs[rdIdxA];
  assign rdDataB = regs[rdIdxB];

endmodule

// File: rtl/addCoreDatapath.sv
module addCoreDatapath
  import addCorePkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int REG_CNT = 16,
  parameter int OPC_W   = 8,
  localparam int IDX_W  = $clog2(REG_CNT),
  localparam int INSTR_HW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] memData,
  output logic [DATA_W-1:0] memAddr,
  output logic [OPC_W-1:0]  opcode,
  output logic              overflow
);

  logic [DATA_W-1:0] irHi;
  logic [DATA_W-1:0] irLo;
  logic [DATA_W-1:0] opndAddr;
  logic [DATA_W-1:0] opndData;
  logic [DATA_W-1:0] sumReg;
  logic [DATA_W-1:0] pcReg;
  logic [DATA_W-1:0] pcNext;
  logic [DATA_W-1:0] baseVal;
  logic [DATA_W-1:0] dstVal;
  logic [DATA_W-1:0] rawSum;
  logic [IDX_W-1:0]  dstIdx;
  logic [IDX_W-1:0]  baseIdx;
  logic              ovfNow;

  // Field split of the first instruction half-word.
  assign opcode  = irHi[DATA_W-1 -: OPC_W];
  assign dstIdx  = irHi[2*IDX_W-1 -: IDX_W];
  assign baseIdx = irHi[IDX_W-1:0];

  addCoreRegFile #(
    .DATA_W  (DATA_W),
    .REG_CNT (REG_CNT)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .rdIdxA  (baseIdx),
    .rdDataA (baseVal),
    .rdIdxB  (dstIdx),
    .rdDataB (dstVal),
    .wrEn    (strobe.writeDst),
    .wrIdx   (dstIdx),
    .wrData  (sumReg)
  );

  assign rawSum = dstVal + opndData;
  assign ovfNow = (dstVal[DATA_W-1] == opndData[DATA_W-1]) &&
                  (rawSum[DATA_W-1] != dstVal[DATA_W-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      irHi     <= '0;
      irLo     <= '0;
      opndAddr <= '0;
      opndData <= '0;
      sumReg   <= '0;
      pcReg    <= '0;
      pcNext   <= '0;
      overflow <= 1'b0;
    end else begin
      if (strobe.loadHi)   irHi     <= memData;
      if (strobe.loadLo)   irLo     <= memData;
      if (strobe.calcAddr) opndAddr <= irLo + baseVal;
      if (strobe.loadOpnd) opndData <= memData;
      if (strobe.doAdd) begin
        sumReg   <= rawSum;
        overflow <= ovfNow;
      end
      if (strobe.incPc)    pcNext   <= pcReg + DATA_W'(INSTR_HW);
      if (strobe.savePc)   pcReg    <= pcNext;
    end
  end

  always_comb begin
    unique case (strobe.addrSel)
      ADR_PC_NEXT: memAddr = pcReg + DATA_W'(1);
      ADR_OPND:    memAddr = opndAddr;
      default:     memAddr = pcReg;
    endcase
  end

endmodule

// File: rtl/addCoreControl.sv
module addCoreControl
  import addCorePkg::*;
#(
  parameter int               OPC_W   = 8,
  parameter logic [OPC_W-1:0] ADD_OPC = 8'h5A
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             memReady,
  input  logic [OPC_W-1:0] opcode,
  output ctrlStrobe_t      strobe,
  output logic             memRead,
  output logic             illegal
);

  seqState_t state;
  seqState_t nextState;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_FETCH_HI;
      illegal <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_DECODE && opcode != ADD_OPC) illegal <= 1'b1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.addrSel = ADR_PC;
    memRead        = 1'b0;
    nextState      = state;
    unique case (state)
      ST_FETCH_HI: begin
        memRead = 1'b1;
        if (memReady) begin
          strobe.loadHi = 1'b1;
          nextState     = ST_DECODE;
        end
      end
      ST_DECODE: begin
        nextState = (opcode == ADD_OPC) ? ST_FETCH_LO : ST_HALT;
      end
      ST_FETCH_LO: begin
        memRead        = 1'b1;
        strobe.addrSel = ADR_PC_NEXT;
        if (memReady) begin
          strobe.loadLo = 1'b1;
          nextState     = ST_CALC;
        end
      end
      ST_CALC: begin
        strobe.calcAddr = 1'b1;
        nextState       = ST_FETCH_OPND;
      end
      ST_FETCH_OPND: begin
        memRead        = 1'b1;
        strobe.addrSel = ADR_OPND;
        if (memReady) begin
          strobe.loadOpnd = 1'b1;
          nextState       = ST_EXEC;
        end
      end
      ST_EXEC: begin
        strobe.doAdd = 1'b1;
        nextState    = ST_WRITE;
      end
      ST_WRITE: begin
        strobe.writeDst = 1'b1;
        nextState       = ST_PC_INC;
      end
      ST_PC_INC: begin
        strobe.incPc = 1'b1;
        nextState    = ST_PC_SAVE;
      end
      ST_PC_SAVE: begin
        strobe.savePc = 1'b1;
        nextState     = ST_FETCH_HI;
      end
      default: begin
        nextState = ST_HALT;
      end
    endcase
  end

endmodule

// File: rtl/addCore.sv
module addCore
  import addCorePkg::*;
#(
  parameter int               DATA_W  = 16,
  parameter int               REG_CNT = 16,
  parameter int               OPC_W   = 8,
  parameter logic [OPC_W-1:0] ADD_OPC = 8'h5A
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] memAddr,
  output logic              memRead,
  input  logic [DATA_W-1:0] memData,
  input  logic              memReady,
  output logic [STAT_W-1:0] status
);

  ctrlStrobe_t      strobe;
  logic [OPC_W-1:0] opcode;
  logic             overflow;
  logic             illegal;

  addCoreControl #(
    .OPC_W   (OPC_W),
    .ADD_OPC (ADD_OPC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .memReady (memReady),
    .opcode   (opcode),
    .strobe   (strobe),
    .memRead  (memRead),
    .illegal  (illegal)
  );

  addCoreDatapath #(
    .DATA_W  (DATA_W),
    .REG_CNT (REG_CNT),
    .OPC_W   (OPC_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .memData  (memData),
    .memAddr  (memAddr),
    .opcode   (opcode),
    .overflow (overflow)
  );

  always_comb begin
    status           = '0;
    status[STAT_OVF] = overflow;
    status[STAT_ILL] = illegal;
  end

endmodule

// File: rtl/addCoreChecker.sv
module addCoreChecker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] memAddr,
  input logic              memRead,
  input logic              memReady,
  input logic              haltFlag
);

  logic [1:0]        rdPhase;
  logic [DATA_W-1:0] firstAddr;
  logic              seenInstr;

  // Tracks which of the three reads of an instruction comes next.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdPhase   <= 2'd0;
      firstAddr <= '0;
      seenInstr <= 1'b0;
    end else if (memRead && memReady) begin
      if (rdPhase == 2'd0) begin
        firstAddr <= memAddr;
        seenInstr <= 1'b1;
      end
      rdPhase <= (rdPhase == 2'd2) ? 2'd0 : rdPhase + 2'd1;
    end
  end

  AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    memRead && !memReady |=> memRead && $stable(memAddr)); // R6

  AST_READ_GAP: assert property (@(posedge clk) disable iff (rst)
    memRead && memReady |=> !memRead); // R7

  AST_LO_ADDR: assert property (@(posedge clk) disable iff (rst)
    memRead && rdPhase == 2'd1 |-> memAddr == firstAddr + DATA_W'(1)); // R2

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    memRead && rdPhase == 2'd0 && seenInstr |-> memAddr == firstAddr + DATA_W'(2)); // R8

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    haltFlag |-> !memRead); // R9

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    haltFlag |=> haltFlag); // R9

endmodule

bind addCore addCoreChecker #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .memAddr  (memAddr),
  .memRead  (memRead),
  .memReady (memReady),
  .haltFlag (status[1])
);

// File: tb/addCore_tb.sv
`timescale 1ns/1ps
module addCore_tb;

  localparam int WATCHDOG = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] memAddr;
  logic        memRead;
  logic [15:0] memData = '0;
  logic        memReady = 1'b0;
  logic [1:0]  status;

  int vectors = 0;
  int misses = 0;
  int cycleCnt = 0;
  int maxWait = 0;

  logic [15:0] mReg [16];
  logic [15:0] mPc;
  bit          lastValid;
  int          lastStamp;
  int          pendWaits;

  addCore u_dut (
    .clk      (clk),
    .rst      (rst),
    .memAddr  (memAddr),
    .memRead  (memRead),
    .memData  (memData),
    .memReady (memReady),
    .status   (status)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycleCnt <= cycleCnt + 1;
    if (cycleCnt == WATCHDOG) begin
      vectors++;
      misses++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycleCnt);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  function automatic bit ovfOf(input logic [15:0] a, input logic [15:0] b, input logic [15:0] s);
    return (a[15] == b[15]) && (s[15] != a[15]);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    memReady = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    foreach (mReg[i]) mReg[i] = '0;
    mPc = '0;
    lastValid = 1'b0;
    pendWaits = 0;
  endtask

  // Serves one read as the memory; returns wait cycles used and completion stamp.
  task automatic acceptRead(input logic [15:0] expAddr, input logic [15:0] data,
                            input string req, output int waits, output int stamp);
    int guard = 0;
    bit held = 1'b1;
    waits = (maxWait == 0) ? 0 : int'($urandom_range(maxWait, 0));
    @(negedge clk);
    while (!memRead && guard < 64) begin
      guard++;
      @(negedge clk);
    end
    check(memRead, req, "read strobe", 32'(memRead), 32'd1);
    check(memAddr == expAddr, req, "read address", 32'(memAddr), 32'(expAddr));
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      if (!(memRead && memAddr == expAddr)) held = 1'b0;
    end
    if (waits > 0)
      check(held, "R6", "hold during wait", {15'd0, memRead, memAddr}, {15'd0, 1'b1, expAddr});
    memReady = 1'b1;
    memData  = data;
    @(negedge clk);
    stamp    = cycleCnt;
    memReady = 1'b0;
    check(!memRead, "R7", "strobe low after completed read", 32'(memRead), 32'd0);
  endtask

  task automatic doInstr(input logic [7:0] opc, input logic [3:0] dst, input logic [3:0] base,
                         input logic [15:0] disp, input logic [15:0] opnd, input string opTag);
    int w1, w2, wd, t1, t2, td;
    logic [15:0] a;
    logic [15:0] s;
    bit v;
    acceptRead(mPc, {opc, dst, base}, lastValid ? "R8" : "R1", w1, t1);
    if (lastValid)
      check(t1 - lastStamp == 9 + pendWaits + w1, "R7", "cycles between instruction starts",
            32'(t1 - lastStamp), 32'(9 + pendWaits + w1));
    lastValid = 1'b1;
    lastStamp = t1;
    if (opc != 8'h5A) return;
    acceptRead(mPc + 16'd1, disp, "R2", w2, t2);
    a = disp + mReg[base];
    acceptRead(a, opnd, opTag, wd, td);
    s = mReg[dst] + opnd;
    v = ovfOf(mReg[dst], opnd, s);
    @(negedge clk);
    check(status[0] == v, "R5", "overflow flag", 32'(status[0]), 32'(v));
    mReg[dst] = s;
    mPc = mPc + 16'd2;
    pendWaits = w2 + wd;
  endtask

  initial begin
    logic [15:0] opnd;
    void'($urandom(32'd4242));
    doReset();
    check(status == 2'b00, "R1", "status after reset", 32'(status), 32'd0);

    // Directed: registers start at zero, overflow corners, address wrap.
    maxWait = 0;
    doInstr(8'h5A, 4'd3, 4'd0, 16'h0100, 16'h7FFF, "R1"); // r3 = 7FFF
    doInstr(8'h5A, 4'd3, 4'd3, 16'h0000, 16'h0001, "R4"); // addr 7FFF, r3 = 8000, ovf
    doInstr(8'h5A, 4'd4, 4'd3, 16'hFFFF, 16'h8000, "R3"); // addr wraps to 7FFF, r4 = 8000
    doInstr(8'h5A, 4'd4, 4'd4, 16'h0000, 16'h8000, "R4"); // addr 8000, r4 = 0, ovf
    doInstr(8'h5A, 4'd5, 4'd4, 16'h1234, 16'hFFFF, "R4"); // addr 1234, r5 = FFFF
    doInstr(8'h5A, 4'd5, 4'd5, 16'h0001, 16'h0001, "R4"); // addr 0000, r5 = 0

    // Random stream with wait states.
    maxWait = 2;
    for (int n = 0; n < 80; n++) begin
      unique case (n % 4)
        0: opnd = 16'h7FFF;
        1: opnd = 16'h8000;
        default: opnd = 16'($urandom);
      endcase
      doInstr(8'h5A, 4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)),
              16'($urandom), opnd, "R3");
    end

    // Illegal opcode halts.
    doInstr(8'hC3, 4'd1, 4'd2, 16'h0000, 16'h0000, "R9");
    repeat (2) @(negedge clk);
    check(status[1] == 1'b1, "R9", "illegal flag set", 32'(status[1]), 32'd1);
    check(!memRead, "R9", "no read while halted", 32'(memRead), 32'd0);
    repeat (30) @(negedge clk);
    check(status[1] == 1'b1, "R9", "illegal flag sticky", 32'(status[1]), 32'd1);
    check(!memRead, "R9", "still no read", 32'(memRead), 32'd0);

    // Reset recovers with registers cleared.
    doReset();
    check(status == 2'b00, "R1", "status after second reset", 32'(status), 32'd0);
    maxWait = 0;
    doInstr(8'h5A, 4'd2, 4'd7, 16'h0042, 16'h1111, "R1");
    maxWait = 1;
    doInstr(8'h5A, 4'd6, 4'd2, 16'h0000, 16'h2222, "R4");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule